// File: doc/BRIEF.md
# Dual-Channel Cascadable Compare Timer

This block holds two 8-bit timer channels behind a small register bus. Each channel has an up-counter, two compare registers (A and B), a count-source selector, a counter-clear selector, a waveform output and three sticky status flags. Each flag drives its own interrupt line through its own enable. The count source is one of three power-of-two taps of the system clock (divide by 8, 64 or 8192), an external event pin, or a link from the other channel. Through that link the two channels form one 16-bit counter, or channel 1 counts the match-A events of channel 0.

Each output waveform is shaped by two independent compare actions: drive low, drive high, toggle or keep. This gives arbitrary duty cycles and PWM. Channel 0's match-A event also yields a one-cycle trigger for an external converter.

The register bus is a plain single-cycle interface. A write is taken on the rising clock edge while `bus_wr_i` is high, and the read data is combinational from `bus_addr_i`. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the stop bit (address 0x10, bit 0) reads 1. While it is set the counters do not move, every channel register reads 0, and writes to channel registers are discarded. Clearing it starts the module.
- R2: Channel n's registers sit at base 8*n. SRC bits [2:0] select the count source: 0 none, 1 clock/8, 2 clock/64, 3 clock/8192, 4 external pin, 5 link. Each selected tick advances the counter by exactly one.
- R3: SRC bits [4:3] pick which edges of the external pin count: 0 rising, 1 falling, 2 or 3 both. The pin passes through a two-stage synchronizer, and an edge is counted within three clock cycles.
- R4: CLR bits [1:0] select the clear event: 0 none, 1 match A, 2 match B, 3 rising edge of the external clear pin. With clear on a compare value C, the counter cycles through 0..C, a period of C+1 ticks.
- R5: A match on compare x happens on a tick where the count equals CMPx. An overflow happens on a tick at all-ones that is not also a clear, and the counter then goes to 0. The events latch in STAT bit 0 (A), bit 1 (B) and bit 2 (overflow).
- R6: ACT bits [1:0] give the action for match A and bits [3:2] the action for match B, coded as 00 keep, 01 low, 10 high, 11 toggle. When both match on one tick, only A's action applies. The output level appears on `wave_o` and in STAT bit 3.
- R7: With channel 0 on source 5, channel 0 counts channel 1 overflows in the same cycle, forming a 16-bit counter with channel 0 as the upper byte.
- R8: With channel 1 on source 5, channel 1 advances once per channel 0 match-A event, one cycle after it.
- R9: Each interrupt output equals its status flag ANDed with the IEN bit in the same position (bit 0 A, bit 1 B, bit 2 overflow).
- R10: Status flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If an event arrives in the same cycle as a clearing write, the flag stays set.
- R11: `adc_trig_o` is a one-cycle pulse in the cycle after each channel 0 match-A event.
- R12: Channel offsets are 0 SRC, 1 CLR, 2 ACT, 3 IEN, 4 STAT, 5 CNT, 6 CMPA, 7 CMPB. Registers read back what was written, and a CNT write replaces the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| ext_clk_i | input | 2 | External event pin per channel |
| ext_clr_i | input | 2 | External counter clear pin per channel |
| wave_o | output | 2 | Waveform output per channel |
| irq_cma_o | output | 2 | Match-A interrupt per channel |
| irq_cmb_o | output | 2 | Match-B interrupt per channel |
| irq_ovf_o | output | 2 | Overflow interrupt per channel |
| adc_trig_o | output | 1 | Converter start pulse from channel 0 match A |

## Verification
The hardest case to reach is a flag-clearing write that lands on the very clock edge where a new match event latches. The prescaler taps give no exact phase control from the ports, so the bench instead drives the channel from its external pin. The pin edge reaches the counter after a fixed synchronizer delay, which lets the bench place the clearing write on the exact edge of the match and sample the converter pulse around it. Random compare values, edge modes, pulse counts and 16-bit start values, taken from a fixed seed, cover the remaining modes.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int AW = 5;

  typedef enum logic [2:0] {
    SRC_OFF = 3'd0, SRC_DIV_LO = 3'd1, SRC_DIV_MID = 3'd2,
    SRC_DIV_HI = 3'd3, SRC_EXT = 3'd4, SRC_LINK = 3'd5
  } src_e;

  typedef enum logic [1:0] {CLR_NONE, CLR_CMA, CLR_CMB, CLR_EXT} clr_e;
  typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOGGLE} act_e;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH, EDGE_ALT} edge_e;

  localparam logic [2:0] OFF_SRC  = 3'd0;
  localparam logic [2:0] OFF_CLR  = 3'd1;
  localparam logic [2:0] OFF_ACT  = 3'd2;
  localparam logic [2:0] OFF_IEN  = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd4;
  localparam logic [2:0] OFF_CNT  = 3'd5;
  localparam logic [2:0] OFF_CMPA = 3'd6;
  localparam logic [2:0] OFF_CMPB = 3'd7;

  localparam logic [AW-1:0] ADDR_STOP = 5'h10;

  localparam int F_CMA = 0;
  localparam int F_CMB = 1;
  localparam int F_OVF = 2;
endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
  parameter int PRE_W   = 13,
  parameter int TAP_LO  = 3,
  parameter int TAP_MID = 6,
  parameter int TAP_HI  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  output logic [2:0] tick_o
);
  logic [PRE_W-1:0] pre_q;

  // Phase restarts from zero whenever the module is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar i = 0; i < 3; i++) begin : g_tap
    localparam int TAP = (i == 0) ? TAP_LO : ((i == 1) ? TAP_MID : TAP_HI);
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << TAP) - 64'd1);
    assign tick_o[i] = run_i && ((pre_q & MASK) == MASK);
  end

  // A slow tap only fires on a cycle where the faster taps fire too.
  assert_tap_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[2] |-> (tick_o[1] && tick_o[0]));
endmodule

// File: rtl/dct_edge.sv
module dct_edge
  import dct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_i,
  input  edge_e sel_i,
  output logic  pulse_o
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    case (sel_i)
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      default:   pulse_o = rise | fall;
    endcase
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
#(
  parameter int CW       = 8,
  parameter bit LINK_OVF = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [2:0]    pre_tick_i,
  input  logic          ext_clk_i,
  input  logic          ext_clr_i,
  input  logic          link_i,
  input  logic          wr_i,
  input  logic [2:0]    off_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          link_o,
  output logic          wave_o,
  output logic          irq_cma_o,
  output logic          irq_cmb_o,
  output logic          irq_ovf_o
);
  src_e          src_q;
  edge_e         edge_q;
  clr_e          clr_q;
  act_e          act_a_q, act_b_q;
  logic [2:0]    ien_q, flag_q;
  logic [CW-1:0] cnt_q, cmpa_q, cmpb_q;
  logic          wave_q;

  logic ext_tick, ext_clr_pulse, src_tick, tick;
  logic ma, mb, ovf, clr_hit, cnt_wr;
  logic [2:0] evt, keep;
  act_e act_sel;

  dct_edge u_clk_edge (.clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i),
                       .sel_i(edge_q), .pulse_o(ext_tick));
  dct_edge u_clr_edge (.clk(clk), .rst_n(rst_n), .pin_i(ext_clr_i),
                       .sel_i(EDGE_RISE), .pulse_o(ext_clr_pulse));

  always_comb begin
    case (src_q)
      SRC_DIV_LO:  src_tick = pre_tick_i[0];
      SRC_DIV_MID: src_tick = pre_tick_i[1];
      SRC_DIV_HI:  src_tick = pre_tick_i[2];
      SRC_EXT:     src_tick = ext_tick;
      SRC_LINK:    src_tick = link_i;
      default:     src_tick = 1'b0;
    endcase
  end

  assign tick   = run_i && src_tick;
  assign ma     = tick && (cnt_q == cmpa_q);
  assign mb     = tick && (cnt_q == cmpb_q);
  assign cnt_wr = wr_i && (off_i == OFF_CNT);

  always_comb begin
    case (clr_q)
      CLR_CMA: clr_hit = ma;
      CLR_CMB: clr_hit = mb;
      CLR_EXT: clr_hit = run_i && ext_clr_pulse;
      default: clr_hit = 1'b0;
    endcase
  end

  assign ovf = tick && (cnt_q == '1) && !clr_hit;
  assign evt = {ovf, mb, ma};
  assign keep = (wr_i && (off_i == OFF_STAT)) ? wdata_i[2:0] : 3'b111;

  // Match A overrides match B on the same tick.
  always_comb begin
    if (ma)      act_sel = act_a_q;
    else if (mb) act_sel = act_b_q;
    else         act_sel = ACT_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_OFF;
      edge_q  <= EDGE_RISE;
      clr_q   <= CLR_NONE;
      act_a_q <= ACT_KEEP;
      act_b_q <= ACT_KEEP;
      ien_q   <= '0;
      cmpa_q  <= '1;
      cmpb_q  <= '1;
    end else if (wr_i) begin
      case (off_i)
        OFF_SRC: begin
          src_q  <= src_e'(wdata_i[2:0]);
          edge_q <= edge_e'(wdata_i[4:3]);
        end
        OFF_CLR: clr_q <= clr_e'(wdata_i[1:0]);
        OFF_ACT: begin
          act_a_q <= act_e'(wdata_i[1:0]);
          act_b_q <= act_e'(wdata_i[3:2]);
        end
        OFF_IEN:  ien_q  <= wdata_i[2:0];
        OFF_CMPA: cmpa_q <= wdata_i;
        OFF_CMPB: cmpb_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= '0;
      wave_q <= 1'b0;
    end else begin
      if (cnt_wr)       cnt_q <= wdata_i;
      else if (clr_hit) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + CW'(1);
      flag_q <= (flag_q & keep) | evt;
      case (act_sel)
        ACT_LOW:    wave_q <= 1'b0;
        ACT_HIGH:   wave_q <= 1'b1;
        ACT_TOGGLE: wave_q <= ~wave_q;
        default:    wave_q <= wave_q;
      endcase
    end
  end

  always_comb begin
    case (off_i)
      OFF_SRC:  rdata_o = {{(CW-5){1'b0}}, edge_q, src_q};
      OFF_CLR:  rdata_o = {{(CW-2){1'b0}}, clr_q};
      OFF_ACT:  rdata_o = {{(CW-4){1'b0}}, act_b_q, act_a_q};
      OFF_IEN:  rdata_o = {{(CW-3){1'b0}}, ien_q};
      OFF_STAT: rdata_o = {{(CW-4){1'b0}}, wave_q, flag_q};
      OFF_CNT:  rdata_o = cnt_q;
      OFF_CMPA: rdata_o = cmpa_q;
      default:  rdata_o = cmpb_q;
    endcase
  end

  if (LINK_OVF) begin : g_link_ovf
    assign link_o = ovf;
  end else begin : g_link_cma
    assign link_o = ma;
  end

  assign wave_o    = wave_q;
  assign irq_cma_o = flag_q[F_CMA] & ien_q[F_CMA];
  assign irq_cmb_o = flag_q[F_CMB] & ien_q[F_CMB];
  assign irq_ovf_o = flag_q[F_OVF] & ien_q[F_OVF];

  assert_stop_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
  assert_clr_cma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q == CLR_CMA && ma && !cnt_wr) |=> (cnt_q == '0));
  assert_ovf_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_wr) |=> (cnt_q == '0));
  assert_keep_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a_q == ACT_KEEP && act_b_q == ACT_KEEP) |=> $stable(wave_q));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ma |=> flag_q[F_CMA]);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CW      = 8,
  parameter int PRE_W   = 13,
  parameter int TAP_LO  = 3,
  parameter int TAP_MID = 6,
  parameter int TAP_HI  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [CW-1:0] bus_wdata_i,
  output logic [CW-1:0] bus_rdata_o,
  input  logic [1:0]    ext_clk_i,
  input  logic [1:0]    ext_clr_i,
  output logic [1:0]    wave_o,
  output logic [1:0]    irq_cma_o,
  output logic [1:0]    irq_cmb_o,
  output logic [1:0]    irq_ovf_o,
  output logic          adc_trig_o
);
  logic          stop_q, run;
  logic [2:0]    pre_tick;
  logic          ch_area, wr0, wr1;
  logic [CW-1:0] rd0, rd1;
  logic          cma0, ovf1, adc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b1;
    else if (bus_wr_i && bus_addr_i == ADDR_STOP) stop_q <= bus_wdata_i[0];
  end
  assign run = !stop_q;

  assign ch_area = !bus_addr_i[AW-1];
  assign wr0 = run && bus_wr_i && ch_area && !bus_addr_i[3];
  assign wr1 = run && bus_wr_i && ch_area &&  bus_addr_i[3];

  dct_prescale #(.PRE_W(PRE_W), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI))
    u_pre (.clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(pre_tick));

  // Channel 0 links to channel 1's overflow (16-bit carry, same cycle).
  dct_chan #(.CW(CW), .LINK_OVF(1'b0)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .pre_tick_i(pre_tick),
    .ext_clk_i(ext_clk_i[0]), .ext_clr_i(ext_clr_i[0]), .link_i(ovf1),
    .wr_i(wr0), .off_i(bus_addr_i[2:0]), .wdata_i(bus_wdata_i), .rdata_o(rd0),
    .link_o(cma0), .wave_o(wave_o[0]), .irq_cma_o(irq_cma_o[0]),
    .irq_cmb_o(irq_cmb_o[0]), .irq_ovf_o(irq_ovf_o[0]));

  // Channel 1 links to the registered match-A pulse of channel 0.
  dct_chan #(.CW(CW), .LINK_OVF(1'b1)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .pre_tick_i(pre_tick),
    .ext_clk_i(ext_clk_i[1]), .ext_clr_i(ext_clr_i[1]), .link_i(adc_q),
    .wr_i(wr1), .off_i(bus_addr_i[2:0]), .wdata_i(bus_wdata_i), .rdata_o(rd1),
    .link_o(ovf1), .wave_o(wave_o[1]), .irq_cma_o(irq_cma_o[1]),
    .irq_cmb_o(irq_cmb_o[1]), .irq_ovf_o(irq_ovf_o[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adc_q <= 1'b0;
    else        adc_q <= cma0;
  end
  assign adc_trig_o = adc_q;

  always_comb begin
    if (bus_addr_i == ADDR_STOP)  bus_rdata_o = {{(CW-1){1'b0}}, stop_q};
    else if (ch_area && run)      bus_rdata_o = bus_addr_i[3] ? rd1 : rd0;
    else                          bus_rdata_o = '0;
  end

  assert_adc_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> $past(cma0));
  assert_no_trig_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && $past(stop_q)) |-> !adc_trig_o);
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  localparam logic [4:0] SRC = 5'd0, CLR = 5'd1, ACT = 5'd2, IEN = 5'd3,
                         STAT = 5'd4, CNT = 5'd5, CMPA = 5'd6, CMPB = 5'd7;
  localparam logic [4:0] CH1 = 5'd8, STOP = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] ext_clk = '0, ext_clr = '0;
  logic [1:0] wave, irq_cma, irq_cmb, irq_ovf;
  logic adc_trig;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ext_clk_i(ext_clk),
    .ext_clr_i(ext_clr), .wave_o(wave), .irq_cma_o(irq_cma), .irq_cmb_o(irq_cmb),
    .irq_ovf_o(irq_ovf), .adc_trig_o(adc_trig));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // which: 0/1 = event pin of channel, 2/3 = clear pin of channel
  task automatic pulse(input int which);
    @(negedge clk);
    if (which < 2) ext_clk[which] = 1'b1; else ext_clr[which-2] = 1'b1;
    repeat (3) @(negedge clk);
    if (which < 2) ext_clk[which] = 1'b0; else ext_clr[which-2] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int mod_next(input int start, input int ticks, input int cmp);
    return (start + ticks) % (cmp + 1);
  endfunction

  function automatic int edges_seen(input int mode, input int pulses);
    return (mode >= 2) ? 2 * pulses : pulses;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, c0, c1;
    int n, a, m, p, k, v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset and stop state
    br(STOP, d); chk("R1 stop bit after reset", d, 1);
    chk("R1 wave low", wave, 0);
    chk("R1 no trigger", adc_trig, 0);
    chk("R1 no irq", {irq_cma, irq_cmb, irq_ovf}, 0);
    br(CNT, d); chk("R1 reads zero while stopped", d, 0);
    bw(CNT, 8'h33); bw(SRC, 8'h01);
    bw(STOP, 8'h00);
    br(STOP, d); chk("R1 stop cleared", d, 0);
    br(CNT, d); chk("R1 count write ignored while stopped", d, 0);
    br(SRC, d); chk("R1 source write ignored while stopped", d, 0);

    // R12: readback
    v = $urandom_range(0, 255);
    bw(CMPA, 8'(v)); br(CMPA, d); chk("R12 compare readback", d, v);
    bw(CNT, 8'h5A); br(CNT, d); chk("R12 count write", d, 8'h5A);

    // R2: prescaled sources
    bw(SRC, 8'h01);
    for (int t = 0; t < 3; t++) begin
      n = $urandom_range(3, 20);
      br(CNT, c0); repeat (8 * n) @(negedge clk); br(CNT, c1);
      chk("R2 divide by 8", c1, (c0 + n) & 8'hFF);
    end
    bw(SRC, 8'h02);
    n = $urandom_range(1, 3);
    br(CNT, c0); repeat (64 * n) @(negedge clk); br(CNT, c1);
    chk("R2 divide by 64", c1, (c0 + n) & 8'hFF);
    bw(SRC, 8'h03);
    br(CNT, c0); repeat (8192 * 2) @(negedge clk); br(CNT, c1);
    chk("R2 divide by 8192", c1, (c0 + 2) & 8'hFF);
    bw(SRC, 8'h00);
    br(CNT, c0); repeat (100) @(negedge clk); br(CNT, c1);
    chk("R2 no source holds", c1, c0);

    // R3: external edges on channel 1
    for (int e = 0; e < 3; e++) begin
      bw(CH1 + SRC, 8'(4 | (e << 3)));
      bw(CH1 + CNT, 8'h00);
      p = $urandom_range(2, 6);
      for (int i = 0; i < p; i++) pulse(1);
      br(CH1 + CNT, d); chk("R3 external edge mode count", d, edges_seen(e, p));
    end

    // R5: overflow on channel 1
    bw(CH1 + SRC, 8'h04); bw(CH1 + STAT, 8'h00); bw(CH1 + CNT, 8'hFE);
    for (int i = 0; i < 3; i++) pulse(1);
    br(CH1 + CNT, d); chk("R5 wrap past all-ones", d, 1);
    br(CH1 + STAT, d); chk("R5 overflow flag", d[2], 1);

    // R4: clear on match A with random compare
    a = $urandom_range(1, 50);
    bw(SRC, 8'h00); bw(CMPA, 8'(a)); bw(CMPB, 8'hFF); bw(CLR, 8'h01);
    bw(CNT, 8'h00); bw(STAT, 8'h00); bw(SRC, 8'h01);
    repeat (16 * (a + 1) + 16) @(negedge clk);
    br(STAT, d);
    chk("R5 match A flag", d[0], 1);
    chk("R5 match B flag untouched", d[1], 0);
    chk("R4 no overflow with clear", d[2], 0);
    m = $urandom_range(5, 100);
    br(CNT, c0); repeat (8 * m) @(negedge clk); br(CNT, c1);
    chk("R4 clear on A period", c1, mod_next(c0, m, a));

    // R4: clear on match B
    a = $urandom_range(1, 50);
    bw(SRC, 8'h00); bw(CMPA, 8'hFF); bw(CMPB, 8'(a)); bw(CLR, 8'h02);
    bw(CNT, 8'h00); bw(SRC, 8'h01);
    repeat (8 * (a + 1)) @(negedge clk);
    m = $urandom_range(5, 100);
    br(CNT, c0); repeat (8 * m) @(negedge clk); br(CNT, c1);
    chk("R4 clear on B period", c1, mod_next(c0, m, a));

    // R4: external clear pin
    bw(SRC, 8'h00); bw(CLR, 8'h03); bw(CNT, 8'h55);
    pulse(2);
    br(CNT, d); chk("R4 external clear", d, 0);
    bw(CLR, 8'h00); bw(CNT, 8'h55);
    pulse(2);
    br(CNT, d); chk("R4 clear pin ignored when not selected", d, 8'h55);

    // R6: output actions on channel 1
    bw(CH1 + STAT, 8'h00);
    bw(CH1 + CMPA, 8'd2); bw(CH1 + CMPB, 8'd5); bw(CH1 + CLR, 8'h02);
    bw(CH1 + ACT, 8'h06); bw(CH1 + CNT, 8'h00);
    for (int i = 0; i < 3; i++) pulse(1);
    chk("R6 match A drives high", wave[1], 1);
    br(CH1 + STAT, d); chk("R6 level in status", d[3], 1);
    for (int i = 0; i < 3; i++) pulse(1);
    chk("R6 match B drives low", wave[1], 0);
    br(CH1 + CNT, d); chk("R4 clear on B restarts", d, 0);
    bw(CH1 + CMPA, 8'd3); bw(CH1 + CMPB, 8'd3); bw(CH1 + CLR, 8'h00);
    bw(CH1 + ACT, 8'h07); bw(CH1 + CNT, 8'h00);
    for (int i = 0; i < 4; i++) pulse(1);
    chk("R6 A toggle wins over B low", wave[1], 1);
    bw(CH1 + ACT, 8'h00); bw(CH1 + CNT, 8'd3);
    pulse(1);
    chk("R6 keep on both", wave[1], 1);

    // R9 and R10: enables and flag clearing
    bw(CH1 + IEN, 8'h01);
    chk("R9 match A irq enabled", irq_cma[1], 1);
    chk("R9 match B irq masked", irq_cmb[1], 0);
    chk("R9 overflow irq masked", irq_ovf[1], 0);
    bw(CH1 + IEN, 8'h02);
    chk("R9 match B irq enabled", irq_cmb[1], 1);
    bw(CH1 + STAT, 8'h06);
    br(CH1 + STAT, d);
    chk("R10 write zero clears A", d[0], 0);
    chk("R10 write one keeps B", d[1], 1);
    bw(CH1 + STAT, 8'h07);
    br(CH1 + STAT, d); chk("R10 write one does not set", d[0], 0);

    // R10 and R11: clearing write on the edge of a match event
    bw(SRC, 8'h04); bw(CLR, 8'h00); bw(CMPA, 8'h10); bw(CNT, 8'h10); bw(STAT, 8'h00);
    @(negedge clk); ext_clk[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 8'h00;
    @(negedge clk); bus_wr = 1'b0;
    chk("R11 trigger pulse high", adc_trig, 1);
    @(negedge clk);
    chk("R11 trigger pulse one cycle", adc_trig, 0);
    br(STAT, d); chk("R10 event wins over clear", d[0], 1);
    br(CNT, d); chk("R5 count after match tick", d, 8'h11);
    ext_clk[0] = 1'b0; repeat (4) @(negedge clk);

    // R7: 16-bit cascade
    v = $urandom_range(0, 65535);
    k = $urandom_range(5, 40);
    bw(CH1 + SRC, 8'h04); bw(CH1 + CLR, 8'h00); bw(CLR, 8'h00);
    bw(SRC, 8'h05);
    bw(CH1 + CNT, 8'(v)); bw(CNT, 8'(v >> 8));
    for (int i = 0; i < k; i++) pulse(1);
    br(CH1 + CNT, c1); br(CNT, c0);
    chk("R7 16-bit count", {c0, c1}, (v + k) & 16'hFFFF);

    // R8: match count mode
    k = $urandom_range(6, 20);
    bw(SRC, 8'h04); bw(CMPA, 8'd3); bw(CLR, 8'h01); bw(CNT, 8'h00);
    bw(CH1 + SRC, 8'h05); bw(CH1 + CNT, 8'h00);
    for (int i = 0; i < k; i++) pulse(0);
    br(CH1 + CNT, d); chk("R8 channel 1 counts match A", d, k / 4);
    br(CNT, d); chk("R8 channel 0 residue", d, k % 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule